// File: doc/BRIEF.md
# CAN Configuration-Hold Sequencer

This block brings a CAN protocol engine safely into a configuration hold, where software can rewrite settings, and back out again. A hold is requested by a software bit or by a debug-mode input. It is honoured only when a hold-enable bit is set and the engine is not in a low-power condition. The request does not take effect at once. The sequencer first waits for the protocol engine to report a state in which stopping is harmless. It then waits for message-handling activity to stay quiet for a set number of cycles.

Once the hold is granted, the bit-time prescaler is gated off. The transmit pin is forced recessive and the receive pin is masked from the core. Writes to the error counters are let through, and the not-ready and acknowledge flags rise. When the request is removed, the acknowledge falls and the prescaler restarts in the same cycle. The pin overrides and the not-ready flag are released one cycle later.

Top module: `canhold_top`

## Requirements
- R1: A hold request exists only when (sw_hold_req or dbg_hold_req) is high and hold_enable is high; with hold_enable low, hold_ack never rises.
- R2: While pwr_disabled or pwr_stopped is high, the request is treated as absent: no hold is entered, and an existing hold is exited.
- R3: After a request, the sequencer waits until proto_state is safe: codes 0 (idle), 1 (intermission), 2 (error-passive) and 3 (bus-off) are safe, and every other code (4 = frame in progress) is not.
- R4: Once the state is safe, it waits for core_busy to be low on IDLE_CONFIRM consecutive cycles. A busy cycle restarts the count, and a non-safe proto_state returns it to the safe-state wait.
- R5: If the request drops during either wait, the sequencer returns to normal running without raising hold_ack or not_ready.
- R6: In the hold, hold_ack=1, not_ready=1 and presc_en=0. With a safe state and no activity from the request onward, hold_ack rises exactly 2+IDLE_CONFIRM clock edges after the request is applied.
- R7: While not_ready is high, tx_pin is 1 and rx_core is 1. Otherwise tx_pin equals tx_core and rx_core equals rx_pin.
- R8: ecnt_wr_en equals ecnt_wr_req only while hold_ack is high. At all other times it is 0, and the write is discarded.
- R9: On exit, hold_ack falls and presc_en rises on the first edge after the request drops, while not_ready stays high for one more cycle.
- R10: After reset: hold_ack=0, not_ready=0, presc_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_hold_req | input | 1 | Software hold request bit |
| dbg_hold_req | input | 1 | Debug-mode hold request |
| hold_enable | input | 1 | Permits a hold request to take effect |
| pwr_disabled | input | 1 | Module is in the disabled low-power condition |
| pwr_stopped | input | 1 | Module is in the stopped low-power condition |
| proto_state | input | PST_W | Protocol state code (0..3 safe, others active) |
| core_busy | input | 1 | Arbitration, matching or buffer move activity in progress |
| tx_core | input | 1 | Transmit bit from the protocol engine |
| rx_pin | input | 1 | Receive line from the bus |
| ecnt_wr_req | input | 1 | Software write strobe to the error counters |
| presc_en | output | 1 | Bit-time prescaler enable |
| tx_pin | output | 1 | Transmit line to the bus |
| rx_core | output | 1 | Receive bit delivered to the protocol engine |
| ecnt_wr_en | output | 1 | Qualified error-counter write enable |
| not_ready | output | 1 | Not-ready status flag |
| hold_ack | output | 1 | Hold acknowledge status flag |

## Verification
The bench builds the block with IDLE_CONFIRM=3 and PST_W=3. The three-cycle drain window lets the bench interrupt a partial count with a busy cycle or with a return to an active frame and watch the count restart. The window also fixes the entry latency at five edges, which the bench measures exactly. PST_W=3 exposes the boundary between code 3, the last safe code, and code 4, the active frame.

// File: rtl/canhold_pkg.sv
package canhold_pkg;
  typedef enum logic [2:0] {
    HS_RUN        = 3'd0,
    HS_WAIT_SAFE  = 3'd1,
    HS_WAIT_DRAIN = 3'd2,
    HS_FROZEN     = 3'd3,
    HS_THAW       = 3'd4
  } hold_st_e;
endpackage

// File: rtl/canhold_rst_sync.sv
module canhold_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/canhold_req.sv
module canhold_req #(
  parameter int PST_W = 3
) (
  input  logic             sw_hold_req,
  input  logic             dbg_hold_req,
  input  logic             hold_enable,
  input  logic             pwr_disabled,
  input  logic             pwr_stopped,
  input  logic [PST_W-1:0] proto_state,
  output logic             hold_req,
  output logic             proto_safe
);
  // codes 0..3 are the quiet protocol states
  localparam logic [PST_W-1:0] SAFE_MAX = PST_W'(3);

  logic low_power;

  always_comb begin
    low_power  = pwr_disabled | pwr_stopped;
    hold_req   = (sw_hold_req | dbg_hold_req) & hold_enable & ~low_power;
    proto_safe = (proto_state <= SAFE_MAX);
  end
endmodule

// File: rtl/canhold_fsm.sv
module canhold_fsm
  import canhold_pkg::*;
#(
  parameter int IDLE_CONFIRM = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold_req,
  input  logic     proto_safe,
  input  logic     core_busy,
  output hold_st_e st_q
);
  localparam int CNT_W = (IDLE_CONFIRM < 2) ? 1 : $clog2(IDLE_CONFIRM + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CONFIRM - 1);

  hold_st_e         st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  assign cnt_en = (st_q == HS_WAIT_SAFE) || (st_q == HS_WAIT_DRAIN);

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = '0;
    case (st_q)
      HS_RUN: begin
        if (hold_req) st_nxt = HS_WAIT_SAFE;
      end
      HS_WAIT_SAFE: begin
        if (!hold_req)      st_nxt = HS_RUN;
        else if (proto_safe) st_nxt = HS_WAIT_DRAIN;
      end
      HS_WAIT_DRAIN: begin
        if (!hold_req)           st_nxt = HS_RUN;
        else if (!proto_safe)    st_nxt = HS_WAIT_SAFE;
        else if (core_busy)      cnt_nxt = '0;
        else if (cnt_q == CNT_LAST) st_nxt = HS_FROZEN;
        else                     cnt_nxt = cnt_q + 1'b1;
      end
      HS_FROZEN: begin
        if (!hold_req) st_nxt = HS_THAW;
      end
      HS_THAW:  st_nxt = HS_RUN;
      default:  st_nxt = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_RUN;
    else        st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  // R5
  abandon_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == HS_WAIT_SAFE || st_q == HS_WAIT_DRAIN) && !hold_req) |=> (st_q == HS_RUN));

  // R4
  drain_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_WAIT_DRAIN && core_busy) |=> (st_q != HS_FROZEN));
endmodule

// File: rtl/canhold_out.sv
module canhold_out
  import canhold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hold_st_e st_q,
  input  logic     tx_core,
  input  logic     rx_pin,
  input  logic     ecnt_wr_req,
  output logic     presc_en,
  output logic     tx_pin,
  output logic     rx_core,
  output logic     ecnt_wr_en,
  output logic     not_ready,
  output logic     hold_ack
);
  logic frozen, pins_held;

  always_comb begin
    frozen     = (st_q == HS_FROZEN);
    pins_held  = frozen || (st_q == HS_THAW);
    hold_ack   = frozen;
    presc_en   = ~frozen;
    not_ready  = pins_held;
    tx_pin     = pins_held ? 1'b1 : tx_core;
    rx_core    = pins_held ? 1'b1 : rx_pin;
    ecnt_wr_en = frozen & ecnt_wr_req;
  end

  // R6
  ack_stops_presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!presc_en && not_ready));

  // R7
  tx_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_ready |-> (tx_pin && rx_core));

  // R8
  ecnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_wr_en |-> hold_ack);
endmodule

// File: rtl/canhold_top.sv
module canhold_top
  import canhold_pkg::*;
#(
  parameter int PST_W        = 3,
  parameter int IDLE_CONFIRM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_hold_req,
  input  logic             dbg_hold_req,
  input  logic             hold_enable,
  input  logic             pwr_disabled,
  input  logic             pwr_stopped,
  input  logic [PST_W-1:0] proto_state,
  input  logic             core_busy,
  input  logic             tx_core,
  input  logic             rx_pin,
  input  logic             ecnt_wr_req,
  output logic             presc_en,
  output logic             tx_pin,
  output logic             rx_core,
  output logic             ecnt_wr_en,
  output logic             not_ready,
  output logic             hold_ack
);
  logic     rst_n_sync, hold_req, proto_safe;
  hold_st_e st_q;

  canhold_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  canhold_req #(.PST_W(PST_W)) req_i (
    .sw_hold_req(sw_hold_req), .dbg_hold_req(dbg_hold_req),
    .hold_enable(hold_enable), .pwr_disabled(pwr_disabled),
    .pwr_stopped(pwr_stopped), .proto_state(proto_state),
    .hold_req(hold_req), .proto_safe(proto_safe)
  );

  canhold_fsm #(.IDLE_CONFIRM(IDLE_CONFIRM)) fsm_i (
    .clk(clk), .rst_n(rst_n_sync), .hold_req(hold_req),
    .proto_safe(proto_safe), .core_busy(core_busy), .st_q(st_q)
  );

  canhold_out out_i (
    .clk(clk), .rst_n(rst_n_sync), .st_q(st_q),
    .tx_core(tx_core), .rx_pin(rx_pin), .ecnt_wr_req(ecnt_wr_req),
    .presc_en(presc_en), .tx_pin(tx_pin), .rx_core(rx_core),
    .ecnt_wr_en(ecnt_wr_en), .not_ready(not_ready), .hold_ack(hold_ack)
  );

  // R3
  ack_after_safe_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(hold_ack) |-> ($past(proto_safe) && !$past(core_busy)));

  // R2
  low_power_block_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((pwr_disabled || pwr_stopped) && !hold_ack) |=> !hold_ack);

  // R9
  exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(hold_ack) |-> (not_ready && presc_en));
endmodule

// File: tb/canhold_top_tb_top.sv
module canhold_top_tb_top;
  localparam int PST_W = 3;
  localparam int IDLE_CONFIRM = 3;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_hold_req = 0, dbg_hold_req = 0, hold_enable = 0;
  logic pwr_disabled = 0, pwr_stopped = 0, core_busy = 0;
  logic tx_core = 1, rx_pin = 1, ecnt_wr_req = 0;
  logic [PST_W-1:0] proto_state = '0;
  logic presc_en, tx_pin, rx_core, ecnt_wr_en, not_ready, hold_ack;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  canhold_top #(.PST_W(PST_W), .IDLE_CONFIRM(IDLE_CONFIRM)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_hold_req(sw_hold_req),
    .dbg_hold_req(dbg_hold_req), .hold_enable(hold_enable),
    .pwr_disabled(pwr_disabled), .pwr_stopped(pwr_stopped),
    .proto_state(proto_state), .core_busy(core_busy), .tx_core(tx_core),
    .rx_pin(rx_pin), .ecnt_wr_req(ecnt_wr_req), .presc_en(presc_en),
    .tx_pin(tx_pin), .rx_core(rx_core), .ecnt_wr_en(ecnt_wr_en),
    .not_ready(not_ready), .hold_ack(hold_ack)
  );

  // {sw, dbg, en, pdis, pstop, state[2:0], busy, ack, nrdy, presc}
  localparam logic [11:0] VEC [0:NVEC-1] = '{
    12'b0_0_0_0_0_000_0_001, // R10 idle running
    12'b1_0_1_0_0_100_0_001, // R3 frame active, wait
    12'b1_0_1_0_0_100_0_001, // R3 still waiting
    12'b1_0_1_0_0_001_1_001, // R4 safe, busy
    12'b1_0_1_0_0_001_1_001, // R4 busy holds count
    12'b1_0_1_0_0_001_0_001, // R4 quiet 1
    12'b1_0_1_0_0_001_0_001, // R4 quiet 2
    12'b1_0_1_0_0_001_0_110, // R6 quiet 3 -> hold
    12'b1_0_1_0_0_100_1_110, // R6 hold ignores engine
    12'b0_0_1_0_0_000_0_011, // R9 ack drops, not_ready stays
    12'b0_0_1_0_0_000_0_001, // R9 released
    12'b0_1_1_0_1_000_0_001, // R2 stopped
    12'b0_1_0_0_0_000_0_001, // R1 enable low
    12'b0_1_1_0_0_011_0_001, // R1 debug request, bus-off
    12'b0_1_1_0_0_011_0_001, // R3 safe
    12'b0_1_1_0_0_011_0_001, // R4 counting
    12'b0_0_1_0_0_011_0_001, // R5 request dropped
    12'b1_0_1_0_0_010_0_001, // R3 error-passive
    12'b1_0_1_0_0_010_0_001, // R4 drain
    12'b1_0_1_0_0_100_0_001, // R4 frame returns
    12'b1_0_1_0_0_000_0_001, // R4 drain restarts
    12'b1_0_1_0_0_000_0_001, // R4 quiet 1
    12'b1_0_1_0_0_000_0_001, // R4 quiet 2
    12'b1_0_1_0_0_000_0_110, // R6 hold again
    12'b1_0_1_1_0_000_0_011, // R2 disabled forces exit
    12'b1_0_1_1_0_000_0_001  // R9 back to running
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R10 reset state
    check("R10", {5'b0, hold_ack, not_ready, presc_en}, 8'b001);

    for (int i = 0; i < NVEC; i++) begin
      {sw_hold_req, dbg_hold_req, hold_enable, pwr_disabled, pwr_stopped,
       proto_state, core_busy} = VEC[i][11:3];
      tick();
      checks++;
      if ({hold_ack, not_ready, presc_en} !== VEC[i][2:0]) begin
        fails++;
        $display("FAIL table row %0d actual=%b expected=%b", i,
                 {hold_ack, not_ready, presc_en}, VEC[i][2:0]);
      end
    end

    // R2 long request under stop condition
    {sw_hold_req, dbg_hold_req, hold_enable, pwr_disabled, pwr_stopped} = 5'b10101;
    proto_state = '0; core_busy = 0;
    lat = 0;
    for (int i = 0; i < 10; i++) begin tick(); lat += int'(hold_ack | not_ready); end
    check("R2", 8'(lat), 8'd0);

    // R1 request with enable low
    {sw_hold_req, dbg_hold_req, hold_enable, pwr_disabled, pwr_stopped} = 5'b11000;
    lat = 0;
    for (int i = 0; i < 10; i++) begin tick(); lat += int'(hold_ack | not_ready); end
    check("R1", 8'(lat), 8'd0);

    // R7 R8 pass-through while running
    {sw_hold_req, dbg_hold_req, hold_enable} = 3'b000;
    tick();
    tx_core = 0; rx_pin = 0; ecnt_wr_req = 1;
    #1;
    check("R7", {6'b0, tx_pin, rx_core}, 8'b00);
    check("R8", {7'b0, ecnt_wr_en}, 8'b0);

    // R6 entry latency
    tx_core = 1; rx_pin = 1; ecnt_wr_req = 0;
    sw_hold_req = 1; hold_enable = 1;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      tick(); lat++;
      if (hold_ack) break;
    end
    check("R6", 8'(lat), 8'(2 + IDLE_CONFIRM));

    // R7 R8 while held
    tx_core = 0; rx_pin = 0; ecnt_wr_req = 1;
    #1;
    check("R7", {6'b0, tx_pin, rx_core}, 8'b11);
    check("R8", {7'b0, ecnt_wr_en}, 8'b1);

    // R9 first exit cycle: pins still held, writes closed
    sw_hold_req = 0;
    tick();
    check("R9", {4'b0, hold_ack, not_ready, presc_en, tx_pin}, 8'b0111);
    check("R8", {7'b0, ecnt_wr_en}, 8'b0);
    tick();
    check("R7", {6'b0, tx_pin, rx_core}, 8'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule